// File: doc/BRIEF.md
# Bridge Driver Enable, Sleep and Fault Supervisor

This block decides, every clock, whether the two motor bridges may conduct, whether the microstep indexer may accept step pulses, and whether the indexer must be forced back to its home position. It combines three active-low control pins (output enable, sleep and logic reset) with three digital fault flags (overcurrent, over-temperature and supply undervoltage). It also drives an active-low fault pin for the host.

Each fault has its own recovery policy. A low supply flag acts like a power-on reset. It has priority over every other input, clears all held state and restarts the wake-up wait. An over-temperature flag shuts the bridges only while it is present. An overcurrent flag must persist for a parameterised number of clocks before it trips. Once tripped, it stays latched until the reset pin is pulled low or the supply drops. Sleep overrides enable and reset. When the block leaves sleep, a parameterised wake-up window must elapse before steps or bridge drive are allowed.

All outputs are registered. A new input combination is therefore reflected at the outputs one clock edge after it is sampled.

Top module: `drv_supervisor`

## Requirements
- R1: While `rst` is high and at the first sample afterwards, `bridge_en` = 0, `idx_run` = 0, `idx_reset` = 1 and `fault_n` = 1.
- R2: When `en_n` is sampled high, `bridge_en` and `idx_run` are 0 at the next edge. When `en_n` is low and every other condition allows it, both are 1.
- R3: When `reset_n` is sampled low while awake, the next edge gives `idx_reset` = 1, `bridge_en` = 0 and `idx_run` = 0, and any latched overcurrent is cleared.
- R4: When `sleep_n` is sampled low with a good supply, `bridge_en`, `idx_run` and `idx_reset` are all 0 at the next edge, whatever `en_n` and `reset_n` are. `reset_n` is ignored during sleep and does not clear a latched overcurrent.
- R5: "Awake" means `sleep_n` = 1 and `uv_flag` = 0. Count the edges at which the block is sampled awake since it was last not awake, or since `rst`. `idx_run` and `bridge_en` stay 0 for the first WAKE_CYC of those edges and may rise at the next one.
- R6: When `ocp_flag` is sampled high on OCP_CYC consecutive awake edges with `reset_n` = 1, the overcurrent latches, and `fault_n` is 0 from the following edge. Shorter bursts leave `fault_n` at 1.
- R7: A latched overcurrent keeps `fault_n` = 0 and `bridge_en` = 0 after `ocp_flag` falls, until `reset_n` is sampled low while awake or `uv_flag` is sampled high.
- R8: When `ot_flag` is sampled high with a good supply, the next edge gives `fault_n` = 0 and `bridge_en` = 0. Both recover by themselves once the flag is low and no overcurrent is latched.
- R9: When `uv_flag` is sampled high, the next edge gives `idx_reset` = 1, `bridge_en` = 0, `idx_run` = 0 and `fault_n` = 1. It also clears the overcurrent latch and restarts the wake count.
- R10: Fault flags never change `idx_run`. Only `uv_flag`, `sleep_n`, `reset_n`, `en_n` and the wake window gate it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low output and step enable |
| sleep_n | input | 1 | Active-low sleep request |
| reset_n | input | 1 | Active-low indexer and fault reset |
| ocp_flag | input | 1 | Raw overcurrent flag, high while over limit |
| ot_flag | input | 1 | Over-temperature flag, high while hot |
| uv_flag | input | 1 | Supply undervoltage flag, high while supply is low |
| bridge_en | output | 1 | Both bridges may conduct |
| idx_run | output | 1 | Indexer may accept step edges |
| idx_reset | output | 1 | Force indexer to home |
| fault_n | output | 1 | Active-low fault indication |

## Verification
Plain control inputs (`en_n`, `sleep_n`, `reset_n`, `ot_flag`, `uv_flag`) show up at the outputs one edge after they are sampled. An overcurrent reaches `fault_n` one edge after its OCP_CYC-th consecutive sample. Step and bridge permission after sleep appears at the edge after WAKE_CYC awake samples. The bench drives inputs on the falling edge and computes the expected outputs for that stimulus from a requirement-level model. At the next falling edge it compares those outputs, so every check lands exactly one register stage after its stimulus.

// File: rtl/sup_pkg.sv
package sup_pkg;
  // Output reset values shared by design and checker
  localparam logic RST_BRIDGE_EN = 1'b0;
  localparam logic RST_IDX_RUN   = 1'b0;
  localparam logic RST_IDX_RESET = 1'b1;
  localparam logic RST_FAULT_N   = 1'b1;

  typedef struct packed {
    logic bridge_en;
    logic idx_run;
    logic idx_reset;
    logic fault_n;
  } sup_out_t;

  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/sup_ocp_qual.sv
module sup_ocp_qual #(
  parameter int unsigned OCP_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic hold_off,
  input  logic flag,
  output logic latched
);
  localparam int unsigned CW = sup_pkg::cnt_width(OCP_CYC);
  localparam logic [CW-1:0] LAST = CW'((OCP_CYC < 1) ? 0 : OCP_CYC - 1);

  logic [CW-1:0] cnt;
  logic          lat;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      lat <= 1'b0;
    end else if (hold_off || !flag) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      lat <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign latched = lat;
endmodule

// File: rtl/sup_wake_timer.sv
module sup_wake_timer #(
  parameter int unsigned WAKE_CYC = 200000
) (
  input  logic clk,
  input  logic rst,
  input  logic awake,
  output logic ready
);
  localparam int unsigned CW = sup_pkg::cnt_width(WAKE_CYC);
  localparam logic [CW-1:0] FULL = CW'(WAKE_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !awake) cnt <= '0;
    else if (cnt != FULL) cnt <= cnt + 1'b1;
  end

  assign ready = (cnt == FULL);
endmodule

// File: rtl/drv_supervisor.sv
module drv_supervisor #(
  parameter int unsigned OCP_CYC  = 16,
  parameter int unsigned WAKE_CYC = 200000
) (
  input  logic clk,
  input  logic rst,
  input  logic en_n,
  input  logic sleep_n,
  input  logic reset_n,
  input  logic ocp_flag,
  input  logic ot_flag,
  input  logic uv_flag,
  output logic bridge_en,
  output logic idx_run,
  output logic idx_reset,
  output logic fault_n
);
  import sup_pkg::*;

  logic awake;
  logic ocp_clr;
  logic ocp_lat;
  logic wake_ok;
  logic may_run;
  sup_out_t nxt, q;

  assign awake   = sleep_n && !uv_flag;
  assign ocp_clr = uv_flag || (awake && !reset_n);

  sup_ocp_qual #(.OCP_CYC(OCP_CYC)) u_ocp (
    .clk      (clk),
    .rst      (rst),
    .clr      (ocp_clr),
    .hold_off (!sleep_n),
    .flag     (ocp_flag),
    .latched  (ocp_lat)
  );

  sup_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk   (clk),
    .rst   (rst),
    .awake (awake),
    .ready (wake_ok)
  );

  // Priority: supply low > sleep > reset > enable
  assign may_run = awake && reset_n && !en_n && wake_ok;

  always_comb begin
    nxt.idx_run   = may_run;
    nxt.bridge_en = may_run && !ocp_lat && !ot_flag;
    nxt.idx_reset = uv_flag || (sleep_n && !reset_n);
    nxt.fault_n   = uv_flag || !(ocp_lat || ot_flag);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q.bridge_en <= RST_BRIDGE_EN;
      q.idx_run   <= RST_IDX_RUN;
      q.idx_reset <= RST_IDX_RESET;
      q.fault_n   <= RST_FAULT_N;
    end else begin
      q <= nxt;
    end
  end

  assign bridge_en = q.bridge_en;
  assign idx_run   = q.idx_run;
  assign idx_reset = q.idx_reset;
  assign fault_n   = q.fault_n;
endmodule

// File: rtl/drv_supervisor_chk.sv
module drv_supervisor_chk (
  input logic clk,
  input logic rst,
  input logic en_n,
  input logic sleep_n,
  input logic reset_n,
  input logic ocp_flag,
  input logic ot_flag,
  input logic uv_flag,
  input logic bridge_en,
  input logic idx_run,
  input logic idx_reset,
  input logic fault_n
);
  AST_UV_SHUTS: assert property (@(posedge clk) disable iff (rst)
    uv_flag |=> (!bridge_en && !idx_run && idx_reset && fault_n)); // R9

  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (rst)
    (!uv_flag && !sleep_n) |=> (!bridge_en && !idx_run && !idx_reset)); // R4

  AST_EN_GATE: assert property (@(posedge clk) disable iff (rst)
    en_n |=> (!bridge_en && !idx_run)); // R2

  AST_RSTN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!uv_flag && sleep_n && !reset_n) |=> (idx_reset && !bridge_en && !idx_run)); // R3

  AST_OT_TRIP: assert property (@(posedge clk) disable iff (rst)
    (!uv_flag && ot_flag) |=> (!fault_n && !bridge_en)); // R8

  AST_WAKE_GAP: assert property (@(posedge clk) disable iff (rst)
    (!uv_flag && $rose(sleep_n)) |=> (!idx_run && !bridge_en)); // R5
endmodule

bind drv_supervisor drv_supervisor_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .en_n      (en_n),
  .sleep_n   (sleep_n),
  .reset_n   (reset_n),
  .ocp_flag  (ocp_flag),
  .ot_flag   (ot_flag),
  .uv_flag   (uv_flag),
  .bridge_en (bridge_en),
  .idx_run   (idx_run),
  .idx_reset (idx_reset),
  .fault_n   (fault_n)
);

// File: tb/tb_drv_supervisor.sv
`timescale 1ns/1ps
module tb_drv_supervisor;
  localparam int unsigned OCP = 5;
  localparam int unsigned WK  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_n = 1'b0, sleep_n = 1'b1, reset_n = 1'b1;
  logic ocp_flag = 1'b0, ot_flag = 1'b0, uv_flag = 1'b0;
  logic bridge_en, idx_run, idx_reset, fault_n;

  always #2.5 clk = ~clk;

  drv_supervisor #(.OCP_CYC(OCP), .WAKE_CYC(WK)) dut (
    .clk(clk), .rst(rst), .en_n(en_n), .sleep_n(sleep_n), .reset_n(reset_n),
    .ocp_flag(ocp_flag), .ot_flag(ot_flag), .uv_flag(uv_flag),
    .bridge_en(bridge_en), .idx_run(idx_run), .idx_reset(idx_reset), .fault_n(fault_n)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // Requirement-level reference state
  int unsigned m_ocp_run;
  int unsigned m_wake;
  bit m_lat;
  bit e_br, e_run, e_rst, e_flt;
  string e_tag;

  task automatic cmp1(input string tag, input string nm, input logic act, input bit exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic compare();
    vectors++;
    cmp1(e_tag, "bridge_en", bridge_en, e_br);
    cmp1(e_tag, "idx_run",   idx_run,   e_run);
    cmp1(e_tag, "idx_reset", idx_reset, e_rst);
    cmp1(e_tag, "fault_n",   fault_n,   e_flt);
  endtask

  // Expected outputs and model update for the inputs of this cycle
  task automatic predict(input string tag);
    bit awake, ready, run;
    awake = sleep_n && !uv_flag;
    ready = (m_wake >= WK);
    run   = awake && reset_n && !en_n && ready;
    e_tag = tag;
    e_run = run;
    e_br  = run && !m_lat && !ot_flag;
    e_rst = uv_flag || (sleep_n && !reset_n);
    e_flt = uv_flag || !(m_lat || ot_flag);
    if (uv_flag || (awake && !reset_n)) begin
      m_lat = 0; m_ocp_run = 0;
    end else if (!sleep_n || !ocp_flag) begin
      m_ocp_run = 0;
    end else begin
      m_ocp_run++;
      if (m_ocp_run >= OCP) m_lat = 1;
    end
    if (!awake) m_wake = 0;
    else if (m_wake < WK) m_wake++;
  endtask

  // One cycle: compare last result, apply new inputs, predict
  task automatic cyc(input string tag, input bit en_n_i, input bit sl_i, input bit rn_i,
                     input bit oc_i, input bit ot_i, input bit uv_i);
    @(negedge clk);
    compare();
    en_n = en_n_i; sleep_n = sl_i; reset_n = rn_i;
    ocp_flag = oc_i; ot_flag = ot_i; uv_flag = uv_i;
    predict(tag);
  endtask

  task automatic run_n(input string tag, input int n, input bit a, input bit b, input bit c,
                       input bit d, input bit e, input bit f);
    for (int i = 0; i < n; i++) cyc(tag, a, b, c, d, e, f);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    bit r_en, r_sl, r_rn, r_oc, r_ot, r_uv;
    void'($urandom(32'h5EED_1234));
    m_ocp_run = 0; m_wake = 0; m_lat = 0;
    e_tag = "R1"; e_br = 0; e_run = 0; e_rst = 1; e_flt = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare();                       // R1 reset values while rst high
    rst = 0;
    predict("R1");                   // first sample after reset
    // R5: wake window after reset with all inputs permissive
    run_n("R5", WK + 4, 0, 1, 1, 0, 0, 0);
    // R2: enable toggling
    run_n("R2", 3, 1, 1, 1, 0, 0, 0);
    run_n("R2", 3, 0, 1, 1, 0, 0, 0);
    // R3: reset pin low
    run_n("R3", 3, 0, 1, 0, 0, 0, 0);
    run_n("R3", 2, 0, 1, 1, 0, 0, 0);
    // R4: sleep overrides enable and reset
    run_n("R4", 4, 0, 0, 0, 0, 0, 0);
    run_n("R5", WK + 3, 0, 1, 1, 0, 0, 0);
    // R6: burst one short, then a full burst
    run_n("R6", OCP - 1, 0, 1, 1, 1, 0, 0);
    run_n("R6", 3, 0, 1, 1, 0, 0, 0);
    run_n("R6", OCP + 2, 0, 1, 1, 1, 0, 0);
    // R7: latch held, survives sleep with reset low, cleared by reset
    run_n("R7", 4, 0, 1, 1, 0, 0, 0);
    run_n("R4", 3, 0, 0, 0, 0, 0, 0);
    run_n("R7", WK + 2, 0, 1, 1, 0, 0, 0);
    run_n("R7", 1, 0, 1, 0, 0, 0, 0);
    run_n("R7", 3, 0, 1, 1, 0, 0, 0);
    // R9: latch again, then clear by supply drop
    run_n("R9", OCP + 1, 0, 1, 1, 1, 0, 0);
    run_n("R9", 3, 0, 1, 0, 1, 1, 1);
    run_n("R9", WK + 3, 0, 1, 1, 0, 0, 0);
    // R8: over-temperature self-clearing
    run_n("R8", 4, 0, 1, 1, 0, 1, 0);
    run_n("R8", 3, 0, 1, 1, 0, 0, 0);
    // R10: random mix with sticky, mostly long runs
    r_en = 0; r_sl = 1; r_rn = 1; r_oc = 0; r_ot = 0; r_uv = 0;
    for (int k = 0; k < 6000; k++) begin
      if ($urandom_range(99) < 3)  r_en = ~r_en;
      if ($urandom_range(199) < 2) r_sl = ~r_sl;
      if ($urandom_range(99) < (r_rn ? 1 : 40)) r_rn = ~r_rn;
      if ($urandom_range(99) < 12) r_oc = ~r_oc;
      if ($urandom_range(99) < 2)  r_ot = ~r_ot;
      if ($urandom_range(299) < (r_uv ? 60 : 1)) r_uv = ~r_uv;
      cyc("R10", r_en, r_sl, r_rn, r_oc, r_ot, r_uv);
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule